// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block is the configuration slave of a signal-processing front end. A host drives a serial clock, a load strobe and one data line. While the strobe is low, every rising clock edge samples one bit. A frame opens with a five-bit header: a direction flag, a three-bit register address and a reserved test bit. Register data follows, least significant bit first. The block holds five configuration registers of different widths, and each has a fixed reset value.

Writes land first in a staging copy of each register. No output changes during a frame. All staged values move to the live registers together when the strobe returns high. One write frame may fill several neighbouring registers in turn, because the address steps up each time a register receives its full length. A read frame returns one register. Its bits are launched on falling clock edges once the header is complete, and an output enable marks the cycles in which the block owns the shared data line.

After reset, an initialisation counter runs for a set number of serial clock cycles. While it runs, a busy flag is raised and writes are dropped. Writing the clear bit of the operation register puts every register back to its reset value.

Top module: `serial_cfg_port`

## Requirements
- R1: While reset is asserted and just after it is released, the live registers read operation 0x000, gain 0x096, clamp 0x080, control 0x000 and fine gain 0x00. `sdo_oe` is 0 and `init_busy` is 1.
- R2: Bits are sampled on rising `sclk` edges only while `sload` is low. The header order is: direction (0 is write, 1 is read), address bit 0, address bit 1, address bit 2, test bit. Data follows, least significant bit first. Address 0 is operation (11 bits), 1 is gain (10 bits), 2 is clamp (8 bits), 3 is control (10 bits) and 4 is fine gain (6 bits).
- R3: In a write frame, the address moves to the next register once the current register has received all its bits. A register left incomplete when the strobe rises keeps its old value. Bits that arrive after register 4 has been filled are dropped. Writes to addresses 5 to 7 change nothing.
- R4: Live register outputs do not change during a frame. All staged values take effect together at the first rising `sclk` edge that samples `sload` high after it was low.
- R5: If the staged operation value has bit 4 set when it is committed, every register (live and staged) returns to its R1 value instead, and bit 4 never appears set on `op_q`.
- R6: `init_busy` stays high for exactly `INIT_CYCLES` rising edges after reset release. Registers completed while it is high are not staged.
- R7: In a read frame, bit k of the addressed live register is on `sdo` after the (5+k)th falling edge of the frame. Bits beyond the register width, and all bits of addresses 5 to 7, read as 0. A read frame changes no register.
- R8: `sdo_oe` is high only in the data phase of a read frame: from the 5th falling edge until `sload` rises. It is low throughout write frames.
- R9: A frame whose test bit is 1 is ignored. It stages nothing and does not raise `sdo_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sload | input | 1 | Load strobe; low frames a transfer, rising commits |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for the shared data pad |
| init_busy | output | 1 | Initialisation period in progress |
| op_q | output | 11 | Live operation register |
| gain_q | output | 10 | Live gain register |
| clamp_q | output | 8 | Live clamp level register |
| ctrl_q | output | 10 | Live control register |
| fgain_q | output | 6 | Live fine gain register |

## Verification
Each address is written and then read back with four arithmetic patterns: all ones, two alternating checkerboards and a mixed value. These patterns expose swapped bit order, a wrong register width, and a mixed-up address decode, since those faults would misplace or clip specific bits. Burst frames start at every address and run to the end of the map. This tells a correct address step and per-register length apart from an off-by-one in either. Trailing, partial and out-of-map bits show that incomplete data is discarded. Test-bit frames, frames sent while busy, and clear-bit commits each show that a suppression path leaves the registers unchanged, or in the case of the clear bit restores them completely, rather than partly.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int NREG    = 5;
  localparam int AW      = 3;
  localparam int HDR_LEN = 5;
  localparam int W_OP    = 11;
  localparam int W_GAIN  = 10;
  localparam int W_CLAMP = 8;
  localparam int W_CTRL  = 10;
  localparam int W_FGAIN = 6;
  localparam int MAXW    = 11;
  localparam int PW      = $clog2(MAXW + 1);
  localparam int OP_CLR_BIT = 4;

  typedef logic [MAXW-1:0] word_t;

  localparam int    WID     [NREG] = '{W_OP, W_GAIN, W_CLAMP, W_CTRL, W_FGAIN};
  localparam word_t RST_VAL [NREG] = '{word_t'(0), word_t'('h096), word_t'('h080),
                                       word_t'(0), word_t'(0)};
endpackage

// File: rtl/serial_cfg_frame.sv
module serial_cfg_frame
  import serial_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sload,
  input  logic          sdi,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output word_t         wr_data,
  output logic          rd_active,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rd_pos,
  output logic          commit
);
  logic [2:0]    hdr_q, hdr_n;
  logic          rnw_q, rnw_n, tst_q, tst_n, sload_q;
  logic [AW-1:0] addr_q, addr_n;
  logic [PW-1:0] pos_q, pos_n;
  word_t         asm_q, asm_n, asm_full;
  logic          hdr_done, data_wr, last_bit;
  int            cur_len;

  always_comb begin
    cur_len = 0;
    for (int i = 0; i < NREG; i++)
      if (addr_q == AW'(i)) cur_len = WID[i];
  end

  assign hdr_done  = (hdr_q == 3'(HDR_LEN));
  assign asm_full  = asm_q | (word_t'(sdi) << pos_q);
  assign data_wr   = !sload && hdr_done && !rnw_q && !tst_q && (int'(addr_q) < NREG);
  assign last_bit  = (int'(pos_q) == cur_len - 1);
  assign wr_en     = data_wr && last_bit;
  assign wr_addr   = addr_q;
  assign wr_data   = asm_full;
  assign rd_active = !sload && hdr_done && rnw_q && !tst_q;
  assign rd_addr   = addr_q;
  assign rd_pos    = pos_q;
  assign commit    = sload && !sload_q;

  always_comb begin
    hdr_n  = hdr_q;
    rnw_n  = rnw_q;
    tst_n  = tst_q;
    addr_n = addr_q;
    pos_n  = pos_q;
    asm_n  = asm_q;
    if (sload) begin
      hdr_n = '0;
      pos_n = '0;
      asm_n = '0;
    end else if (!hdr_done) begin
      hdr_n = hdr_q + 3'd1;
      case (hdr_q)
        3'd0: begin rnw_n = sdi; addr_n = '0; end
        3'd1: addr_n[0] = sdi;
        3'd2: addr_n[1] = sdi;
        3'd3: addr_n[2] = sdi;
        default: tst_n = sdi;
      endcase
    end else if (data_wr) begin
      if (last_bit) begin
        addr_n = addr_q + AW'(1);
        pos_n  = '0;
        asm_n  = '0;
      end else begin
        pos_n = pos_q + PW'(1);
        asm_n = asm_full;
      end
    end else if (pos_q != {PW{1'b1}}) begin
      pos_n = pos_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q   <= '0;
      rnw_q   <= 1'b0;
      tst_q   <= 1'b0;
      addr_q  <= '0;
      pos_q   <= '0;
      asm_q   <= '0;
      sload_q <= 1'b1;
    end else begin
      hdr_q   <= hdr_n;
      rnw_q   <= rnw_n;
      tst_q   <= tst_n;
      addr_q  <= addr_n;
      pos_q   <= pos_n;
      asm_q   <= asm_n;
      sload_q <= sload;
    end
  end

  AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !sload);                                                    // R2
  AST_WR_ADDR_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NREG));                                    // R3
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
  import serial_cfg_pkg::*;
#(
  parameter int INIT_CYCLES = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_data,
  input  logic          commit,
  output logic          busy,
  output word_t         live_o [NREG]
);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          wr_ok, do_clear;
  word_t         shad_w [NREG];
  logic [NREG*MAXW-1:0] live_flat;

  assign busy     = (cnt_q != '0);
  assign cnt_n    = busy ? cnt_q - CW'(1) : cnt_q;
  assign wr_ok    = wr_en && !busy;
  assign do_clear = shad_w[0][OP_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(INIT_CYCLES);
    else        cnt_q <= cnt_n;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam word_t MASK = word_t'((1 << WID[g]) - 1);
    word_t shad_r, shad_n, live_r, live_n;

    always_comb begin
      shad_n = shad_r;
      live_n = live_r;
      if (wr_ok && (wr_addr == AW'(g))) shad_n = wr_data & MASK;
      if (commit) begin
        if (do_clear) begin
          shad_n = RST_VAL[g];
          live_n = RST_VAL[g];
        end else begin
          live_n = shad_r;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shad_r <= RST_VAL[g];
        live_r <= RST_VAL[g];
      end else begin
        shad_r <= shad_n;
        live_r <= live_n;
      end
    end

    assign shad_w[g] = shad_r;
    assign live_o[g] = live_r;
    assign live_flat[g*MAXW +: MAXW] = live_r;
  end

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live_flat));                                      // R4
  AST_CLEAR_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !live_o[0][OP_CLR_BIT]);                                              // R5
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(live_flat));                                         // R6
endmodule

// File: rtl/serial_cfg_readout.sv
module serial_cfg_readout
  import serial_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_active,
  input  logic [AW-1:0] rd_addr,
  input  logic [PW-1:0] rd_pos,
  input  word_t         live_i [NREG],
  output logic          sdo_q,
  output logic          oe_q
);
  logic  bit_n;
  word_t shifted;

  always_comb begin
    bit_n   = 1'b0;
    shifted = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == AW'(i) && int'(rd_pos) < WID[i]) begin
        shifted = live_i[i] >> rd_pos;
        bit_n   = shifted[0];
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sdo_q <= rd_active ? bit_n : 1'b0;
      oe_q  <= rd_active;
    end
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_pkg::*;
#(
  parameter int INIT_CYCLES = 2048
) (
  input  logic               sclk,
  input  logic               rst_n,
  input  logic               sload,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               init_busy,
  output logic [W_OP-1:0]    op_q,
  output logic [W_GAIN-1:0]  gain_q,
  output logic [W_CLAMP-1:0] clamp_q,
  output logic [W_CTRL-1:0]  ctrl_q,
  output logic [W_FGAIN-1:0] fgain_q
);
  logic          wr_en, rd_active, commit, oe_q;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] rd_pos;
  word_t         wr_data;
  word_t         live [NREG];

  serial_cfg_frame u_frame (
    .clk(sclk), .rst_n(rst_n), .sload(sload), .sdi(sdi),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_active(rd_active), .rd_addr(rd_addr), .rd_pos(rd_pos), .commit(commit)
  );

  serial_cfg_bank #(.INIT_CYCLES(INIT_CYCLES)) u_bank (
    .clk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .busy(init_busy), .live_o(live)
  );

  serial_cfg_readout u_rd (
    .clk(sclk), .rst_n(rst_n), .rd_active(rd_active), .rd_addr(rd_addr),
    .rd_pos(rd_pos), .live_i(live), .sdo_q(sdo), .oe_q(oe_q)
  );

  assign sdo_oe  = oe_q && !sload;
  assign op_q    = live[0][W_OP-1:0];
  assign gain_q  = live[1][W_GAIN-1:0];
  assign clamp_q = live[2][W_CLAMP-1:0];
  assign ctrl_q  = live[3][W_CTRL-1:0];
  assign fgain_q = live[4][W_FGAIN-1:0];
endmodule

// File: tb/serial_cfg_port_tb.sv
`timescale 1ns/1ps
module serial_cfg_port_tb;
  localparam int INIT = 40;

  logic sclk = 1'b0, rst_n = 1'b0, sload = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, init_busy;
  logic [10:0] op_q;
  logic [9:0]  gain_q, ctrl_q;
  logic [7:0]  clamp_q;
  logic [5:0]  fgain_q;

  serial_cfg_port #(.INIT_CYCLES(INIT)) u_dut (
    .sclk(sclk), .rst_n(rst_n), .sload(sload), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .init_busy(init_busy), .op_q(op_q), .gain_q(gain_q),
    .clamp_q(clamp_q), .ctrl_q(ctrl_q), .fgain_q(fgain_q)
  );

  always #2 sclk = ~sclk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int bw [5] = '{11, 10, 8, 10, 6};
  logic [10:0] rv [5] = '{11'h000, 11'h096, 11'h080, 11'h000, 11'h000};
  logic [10:0] lm [5], sm [5], wv [5];
  logic q [$];

  always @(posedge sclk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic [10:0] mask_of(int a);
    return (a < 5) ? 11'((1 << bw[a]) - 1) : 11'h0;
  endfunction

  function automatic logic [10:0] get_live(int a);
    case (a)
      0: return op_q;
      1: return 11'(gain_q);
      2: return 11'(clamp_q);
      3: return 11'(ctrl_q);
      default: return 11'(fgain_q);
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(string req);
    for (int a = 0; a < 5; a++) check(32'(get_live(a)), 32'(lm[a]), req, $sformatf("live reg %0d", a));
  endtask

  task automatic add_header(bit rnw, int addr, bit tst);
    q.push_back(rnw);
    for (int i = 0; i < 3; i++) q.push_back(addr[i]);
    q.push_back(tst);
  endtask

  // Sends q; R4 checks outputs are unchanged before the strobe rises; R8 checks oe low.
  task automatic run_wframe();
    @(posedge sclk); #1;
    sload = 1'b0;
    foreach (q[i]) begin
      sdi = q[i];
      @(posedge sclk); #1;
    end
    cmp_all("R4 pre-commit");
    check(32'(sdo_oe), 0, "R8", "oe during write frame");
    sload = 1'b1;
    sdi   = 1'b0;
    @(posedge sclk); #1;
  endtask

  task automatic commit_model();
    if (sm[0][4]) begin
      for (int a = 0; a < 5; a++) begin sm[a] = rv[a]; lm[a] = rv[a]; end
    end else begin
      for (int a = 0; a < 5; a++) lm[a] = sm[a];
    end
  endtask

  // Write nregs registers from start using wv[], then extra trailing bits.
  task automatic do_write(int start, int nregs, int extra, bit tst, bit ignore, string req);
    q.delete();
    add_header(1'b0, start, tst);
    for (int r = 0; r < nregs; r++) begin
      int a = start + r;
      int len = (a < 5) ? bw[a] : 8;
      for (int i = 0; i < len; i++) q.push_back(wv[r][i]);
      if (a < 5 && !tst && !ignore) sm[a] = wv[r] & mask_of(a);
    end
    for (int i = 0; i < extra; i++) q.push_back(1'(((i * 5) + 3) % 2 == 1 || i == 0));
    run_wframe();
    commit_model();
    cmp_all(req);
  endtask

  task automatic do_read(int addr, bit tst, string req);
    logic [11:0] got = '0;
    logic [11:0] exp;
    q.delete();
    add_header(1'b1, addr, tst);
    @(posedge sclk); #1;
    sload = 1'b0;
    foreach (q[i]) begin
      sdi = q[i];
      @(posedge sclk); #1;
    end
    sdi = 1'b0;
    check(32'(sdo_oe), 0, "R8", "oe during read header");
    for (int k = 0; k < 12; k++) begin
      @(negedge sclk); #1;
      got[k] = sdo;
      if (k == 0 || k == 11) check(32'(sdo_oe), 32'(!tst), tst ? "R9" : "R8", "oe in data phase");
      @(posedge sclk); #1;
    end
    exp = (addr < 5 && !tst) ? 12'(lm[addr]) : 12'h0;
    check(32'(got), 32'(exp), tst ? "R9" : "R7", $sformatf("readback addr %0d", addr));
    sload = 1'b1;
    #0;
    check(32'(sdo_oe), 0, "R8", "oe after strobe rises");
    @(posedge sclk); #1;
    commit_model();
    cmp_all("R7 read leaves regs");
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 5; a++) begin lm[a] = rv[a]; sm[a] = rv[a]; end
    repeat (3) @(posedge sclk);
    #1;
    cmp_all("R1 in reset");
    check(32'(sdo_oe), 0, "R1", "oe in reset");
    check(32'(init_busy), 1, "R1", "busy in reset");
    rst_n = 1'b1;

    // R6: write completed while busy is dropped
    wv[0] = 11'h3FF;
    do_write(1, 1, 0, 1'b0, 1'b1, "R6 write while busy");
    while (cyc != INIT - 1) begin @(posedge sclk); #1; end
    check(32'(init_busy), 1, "R6", "busy one edge before end");
    @(posedge sclk); #1;
    check(32'(init_busy), 0, "R6", "busy after INIT edges");

    // R2 R7: single writes and readback, four patterns per address
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 5; a++) begin
        case (p)
          0: wv[0] = 11'h7FF;
          1: wv[0] = 11'h555;
          2: wv[0] = 11'h2AA;
          default: wv[0] = 11'((a * 'h1D3 + 'h0B7) & 'h7FF);
        endcase
        if (a == 0) wv[0][4] = 1'b0;
        do_write(a, 1, 0, 1'b0, 1'b0, "R2 single write");
        do_read(a, 1'b0, "R7");
      end
    end

    // R3: bursts from every start address to the end of the map
    for (int s = 0; s < 5; s++) begin
      for (int r = 0; r < 5; r++) wv[r] = 11'(((s * 97) + (r * 'h15B) + 'h3C) & 'h7FF);
      if (s == 0) wv[0][4] = 1'b0;
      do_write(s, 5 - s, (s == 0) ? 9 : 0, 1'b0, 1'b0, "R3 burst");
      for (int a = 0; a < 5; a++) do_read(a, 1'b0, "R7");
    end

    // R3: trailing partial register is discarded
    wv[0] = 11'h1C7;
    do_write(2, 1, 4, 1'b0, 1'b0, "R3 partial next reg");
    // R3: unmapped addresses
    wv[0] = 11'h0FF;
    do_write(5, 1, 0, 1'b0, 1'b0, "R3 addr 5");
    do_write(7, 1, 0, 1'b0, 1'b0, "R3 addr 7");
    do_read(6, 1'b0, "R7");

    // R9: test bit set
    wv[0] = 11'h2F1;
    do_write(1, 1, 0, 1'b1, 1'b0, "R9 test write ignored");
    do_read(1, 1'b1, "R9");

    // R5: clear bit restores every register
    wv[0] = 11'h010;
    do_write(0, 1, 0, 1'b0, 1'b0, "R5 clear commit");
    do_read(0, 1'b0, "R5");
    wv[0] = 11'h123;
    do_write(3, 1, 0, 1'b0, 1'b0, "R5 write after clear");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule